// File: doc/BRIEF.md
# Memory Mat with Metadata Operations

This block is a single-port storage mat of 512 words. Each word is 36 bits wide: a 32-bit data field and a 4-bit metadata field. The metadata field holds per-word state such as valid, dirty or replacement bits. Apart from plain reads and writes, the mat can do three more things:

- force chosen metadata columns to one or zero in every word at once;
- update one word's metadata from its own old value;
- compare a key against a stored word, with parts of the key masked out.

A typical use is a cache tag store, where a single compare checks both the tag and a valid bit.

Requests enter through one pipelined port that takes a new access every cycle. A request sampled at clock edge k returns its response registered at edge k+1, so the response can be read during the cycle after that edge. Requests always behave as if they ran one at a time in the order they were issued.

Top module: `mem_mat`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is low and the metadata of every word reads as 0.
- R2: A READ (op 0) sampled at edge k returns the stored data and metadata with `rsp_valid` high, registered at edge k+1. A WRITE (op 1) replaces both fields of the addressed word.
- R3: Reads issued on consecutive cycles return on consecutive cycles, in issue order.
- R4: GANG_SET (op 2) sets, in all 512 words, each metadata bit whose `req_mask` bit is 1. The other metadata bits and all data bits are unchanged.
- R5: GANG_CLR (op 3) clears, in all words, each metadata bit whose `req_mask` bit is 1. Everything else is left as it was.
- R6: META_RMW (op 4) responds with the word's old data and old metadata. It then stores the metadata value `(old & req_and) | req_or` and leaves the data field unchanged.
- R7: Any access issued in the cycle right after a META_RMW or WRITE to the same address sees the updated word. This includes another META_RMW and a compare.
- R8: A gang operation or WRITE issued in the cycle right after a META_RMW takes effect after that META_RMW, following request order.
- R9: COMPARE (op 5) sets `rsp_hit` when the stored data equals `req_data` and every metadata bit whose `req_mask` bit is 1 equals the matching bit of `req_meta`. Metadata bits whose mask bit is 0 are ignored.
- R10: COMPARE_META (op 6) ignores the whole 32-bit data field. Its hit depends only on the masked metadata bits, and it always hits when `req_mask` is 0.
- R11: WRITE, GANG_SET, GANG_CLR and NOP (op 7) produce no response. NOP changes no stored state.
- R12: `rsp_hit` is 0 on the responses to READ and META_RMW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_addr | input | 9 | Word address |
| req_data | input | 32 | Write data or compare key data |
| req_meta | input | 4 | Write metadata or compare key metadata |
| req_mask | input | 4 | Gang column select, or compare metadata care mask |
| req_and | input | 4 | META_RMW AND mask |
| req_or | input | 4 | META_RMW OR mask |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Data of the addressed word |
| rsp_meta | output | 4 | Metadata of the addressed word (old value for META_RMW) |
| rsp_hit | output | 1 | Compare result |

## Verification
Corrupted metadata state shows up in the metadata read back or in a compare hit. It appears in the second cycle after the first access that touches the damaged word. A fault in the gang logic can hide until a word that was not recently addressed is read, so reads are spread over the first and last words and words in between. Faults in forwarding or in ordering appear only when same-address requests are issued back to back. These include a stale metadata value returned after a META_RMW, and a gang or write that is lost or overwritten. The stimulus therefore issues those pairs with no idle cycle between them and reads the word straight afterwards.

// File: rtl/mat_pkg.sv
// Package: shared sizes and the operation encoding of the memory mat.
// Assumes: nothing; pure type and constant definitions.
package mat_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_GSET  = 3'd2,
        OP_GCLR  = 3'd3,
        OP_RMW   = 3'd4,
        OP_CMP   = 3'd5,
        OP_CMPM  = 3'd6,
        OP_NOP   = 3'd7
    } mat_op_t;

    // Returns 1 for operations that produce a response.
    function automatic logic op_responds(mat_op_t op);
        return (op == OP_READ) || (op == OP_RMW) || (op == OP_CMP) || (op == OP_CMPM);
    endfunction

endpackage

// File: rtl/mat_data_array.sv
// Module: synchronous single-port storage for the data field of each word.
// Assumes: at most one access per cycle; the read result is registered, so a
// write at edge k is visible to a read sampled at edge k+1.
module mat_data_array #(
    parameter int WORDS = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store_q [WORDS];

    // Write the array when asked.
    always_ff @(posedge clk) begin
        if (wr_en) store_q[addr] <= wdata;
    end

    // Register the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= store_q[addr];
    end

endmodule

// File: rtl/mat_meta_store.sv
// Module: flop-based metadata columns with whole-column gang update,
// metadata write-back for read-modify-write, and a forwarded read port.
// Assumes: the write-back belongs to the request before the current one, so it
// is applied first and the current write or gang is applied on top of it.
module mat_meta_store #(
    parameter int WORDS = 512,
    parameter int MW    = 4,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [MW-1:0] rd_meta,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [MW-1:0] wr_meta,
    input  logic          gang_en,
    input  logic          gang_set,
    input  logic [MW-1:0] gang_mask,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [MW-1:0] wb_meta
);

    logic [MW-1:0] meta_q [WORDS];

    // Read port: take the pending write-back value when it targets this word.
    always_comb begin
        if (wb_en && (wb_addr == rd_addr)) rd_meta = wb_meta;
        else                               rd_meta = meta_q[rd_addr];
    end

    // Update every word: older write-back first, then this cycle's write or gang.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            logic [MW-1:0] nxt;
            nxt = meta_q[i];
            if (!rst_n) begin
                nxt = '0;
            end else begin
                if (wb_en && (wb_addr == AW'(i))) nxt = wb_meta;
                if (wr_en && (wr_addr == AW'(i))) nxt = wr_meta;
                if (gang_en) nxt = gang_set ? (nxt | gang_mask) : (nxt & ~gang_mask);
            end
            meta_q[i] <= nxt;
        end
    end

    // R4
    gang_set_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gang_en && gang_set) |=> (((meta_q[0] & $past(gang_mask)) == $past(gang_mask)) &&
                                   ((meta_q[WORDS-1] & $past(gang_mask)) == $past(gang_mask))));

    // R5
    gang_clr_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gang_en && !gang_set) |=> (((meta_q[0] & $past(gang_mask)) == '0) &&
                                    ((meta_q[WORDS-1] & $past(gang_mask)) == '0)));

    // R6
    rmw_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !wr_en && !gang_en) |=> (meta_q[$past(wb_addr)] == $past(wb_meta)));

    // R8
    gang_after_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && gang_en) |=> (meta_q[$past(wb_addr)] ==
            ($past(gang_set) ? ($past(wb_meta) | $past(gang_mask))
                             : ($past(wb_meta) & ~$past(gang_mask)))));

endmodule

// File: rtl/mat_compare.sv
// Module: maskable key compare against one stored word.
// Assumes: meta_care selects metadata bits that must match; data_care low
// removes the whole data field from the match.
module mat_compare #(
    parameter int DW = 32,
    parameter int MW = 4
) (
    input  logic [DW-1:0] stored_data,
    input  logic [MW-1:0] stored_meta,
    input  logic [DW-1:0] key_data,
    input  logic [MW-1:0] key_meta,
    input  logic [MW-1:0] meta_care,
    input  logic          data_care,
    output logic          hit
);

    logic data_ok;
    logic meta_ok;

    // Combine the data match and the masked metadata match.
    always_comb begin
        data_ok = !data_care || (stored_data == key_data);
        meta_ok = ((stored_meta ^ key_meta) & meta_care) == '0;
        hit     = data_ok && meta_ok;
    end

    // R10
    always_comb begin
        if (!data_care && (meta_care == '0)) begin
            all_masked_hit_chk: assert (hit);
        end
    end

endmodule

// File: rtl/mem_mat.sv
// Module: two-stage pipelined memory mat with metadata gang, read-modify-write
// and masked compare. Stage 1 registers the request and reads the array;
// stage 2 writes back read-modify-write results and registers the response.
// Assumes: one request per cycle at most; requests take effect in issue order.
module mem_mat
    import mat_pkg::*;
#(
    parameter int WORDS = 512,
    parameter int DW    = 32,
    parameter int MW    = 4,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [MW-1:0] req_meta,
    input  logic [MW-1:0] req_mask,
    input  logic [MW-1:0] req_and,
    input  logic [MW-1:0] req_or,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [MW-1:0] rsp_meta,
    output logic          rsp_hit
);

    mat_op_t       op_in;
    logic          s1_valid;
    mat_op_t       s1_op;
    logic [AW-1:0] s1_addr;
    logic [MW-1:0] s1_meta;
    logic [DW-1:0] s1_key_data;
    logic [MW-1:0] s1_key_meta;
    logic [MW-1:0] s1_mask;
    logic [MW-1:0] s1_and;
    logic [MW-1:0] s1_or;
    logic [DW-1:0] arr_rdata;
    logic [MW-1:0] meta_rd;
    logic          wb_en;
    logic [MW-1:0] wb_meta;
    logic          cmp_hit;
    logic          do_write;
    logic          do_gang;

    // Decode the incoming request.
    always_comb begin
        op_in    = mat_op_t'(req_op);
        do_write = req_valid && (op_in == OP_WRITE);
        do_gang  = req_valid && ((op_in == OP_GSET) || (op_in == OP_GCLR));
    end

    // Compute the metadata write-back of a read-modify-write in stage 1.
    always_comb begin
        wb_en   = s1_valid && (s1_op == OP_RMW);
        wb_meta = (s1_meta & s1_and) | s1_or;
    end

    mat_data_array #(.WORDS(WORDS), .DW(DW)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (do_write),
        .addr  (req_addr),
        .wdata (req_data),
        .rdata (arr_rdata)
    );

    mat_meta_store #(.WORDS(WORDS), .MW(MW)) u_meta (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (req_addr),
        .rd_meta   (meta_rd),
        .wr_en     (do_write),
        .wr_addr   (req_addr),
        .wr_meta   (req_meta),
        .gang_en   (do_gang),
        .gang_set  (op_in == OP_GSET),
        .gang_mask (req_mask),
        .wb_en     (wb_en),
        .wb_addr   (s1_addr),
        .wb_meta   (wb_meta)
    );

    mat_compare #(.DW(DW), .MW(MW)) u_cmp (
        .stored_data (arr_rdata),
        .stored_meta (s1_meta),
        .key_data    (s1_key_data),
        .key_meta    (s1_key_meta),
        .meta_care   (s1_mask),
        .data_care   (s1_op == OP_CMP),
        .hit         (cmp_hit)
    );

    // Stage 1: capture the request and its (forwarded) metadata.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_op       <= OP_NOP;
            s1_addr     <= '0;
            s1_meta     <= '0;
            s1_key_data <= '0;
            s1_key_meta <= '0;
            s1_mask     <= '0;
            s1_and      <= '0;
            s1_or       <= '0;
        end else begin
            s1_valid    <= req_valid;
            s1_op       <= op_in;
            s1_addr     <= req_addr;
            s1_meta     <= meta_rd;
            s1_key_data <= req_data;
            s1_key_meta <= req_meta;
            s1_mask     <= req_mask;
            s1_and      <= req_and;
            s1_or       <= req_or;
        end
    end

    // Stage 2: register the response for operations that return one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_meta  <= '0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= s1_valid && op_responds(s1_op);
            rsp_data  <= arr_rdata;
            rsp_meta  <= s1_meta;
            rsp_hit   <= s1_valid && ((s1_op == OP_CMP) || (s1_op == OP_CMPM)) && cmp_hit;
        end
    end

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    // R11
    no_rsp_for_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd7))
        |=> ##1 !rsp_valid);

    // R12
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

endmodule

// File: tb/tb_mem_mat.sv
// Scoreboard bench: the driver updates a reference model in request order and
// queues expected responses; the monitor compares them as responses appear.
module tb_mem_mat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd7;
    logic [8:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_meta = '0;
    logic [3:0]  req_mask = '0;
    logic [3:0]  req_and = '0;
    logic [3:0]  req_or = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [3:0]  rsp_meta;
    logic        rsp_hit;

    mem_mat dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_meta(req_meta),
        .req_mask(req_mask), .req_and(req_and), .req_or(req_or),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_meta(rsp_meta),
        .rsp_hit(rsp_hit)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          cyc;
        logic [31:0] d;
        logic [3:0]  m;
        logic        h;
        bit          chk_d;
        bit          is_cmp;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] mdl_data [512];
    logic [3:0]  mdl_meta [512];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver: present one request at a negedge and update the model.
    task automatic issue(input logic [2:0] op, input int a, input logic [31:0] d,
                         input logic [3:0] m, input logic [3:0] mk, input logic [3:0] an,
                         input logic [3:0] orv, input string tag, input bit chk_d = 1'b1);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = 9'(a); req_data = d;
        req_meta = m; req_mask = mk; req_and = an; req_or = orv;
        e.cyc = cyc; e.d = mdl_data[a]; e.m = mdl_meta[a]; e.h = 1'b0;
        e.chk_d = chk_d; e.is_cmp = 1'b0; e.tag = tag;
        case (op)
            3'd0: q.push_back(e);
            3'd1: begin mdl_data[a] = d; mdl_meta[a] = m; end
            3'd2: for (int i = 0; i < 512; i++) mdl_meta[i] = mdl_meta[i] | mk;
            3'd3: for (int i = 0; i < 512; i++) mdl_meta[i] = mdl_meta[i] & ~mk;
            3'd4: begin q.push_back(e); mdl_meta[a] = (mdl_meta[a] & an) | orv; end
            3'd5, 3'd6: begin
                e.is_cmp = 1'b1;
                e.h = ((op == 3'd6) || (mdl_data[a] == d)) && (((mdl_meta[a] ^ m) & mk) == 4'd0);
                q.push_back(e);
            end
            default: ;
        endcase
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0; req_op = 3'd7;
        end
    endtask

    // Monitor: pop the due item and compare, or flag an unexpected response.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].cyc + 2 == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(rsp_valid == 1'b1, {e.tag, " R2 response present"}, 64'(rsp_valid), 64'd1);
                if (e.chk_d) check(rsp_data == e.d, {e.tag, " data"}, 64'(rsp_data), 64'(e.d));
                check(rsp_meta == e.m, {e.tag, " meta"}, 64'(rsp_meta), 64'(e.m));
                check(rsp_hit == e.h, e.is_cmp ? {e.tag, " hit"} : {e.tag, " R12 hit"},
                      64'(rsp_hit), 64'(e.h));
            end else if (rsp_valid) begin
                check(1'b0, "R11 unexpected response", 64'(rsp_valid), 64'd0);
            end
        end
    end

    task automatic quiet(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, tag, 64'(rsp_valid), 64'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin mdl_data[i] = '0; mdl_meta[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, metadata reads as zero
        quiet(3, "R1 rsp_valid after reset");
        issue(3'd0, 7, 0, 0, 0, 0, 0, "R1 reset meta", 1'b0);
        issue(3'd0, 511, 0, 0, 0, 0, 0, "R1 reset meta", 1'b0);
        idle(3);
        // R2 / R11: write burst with a NOP, then nothing comes back
        issue(3'd1, 0,   32'hDEAD_BEEF, 4'hA, 0, 0, 0, "R2");
        issue(3'd1, 1,   32'h0000_0001, 4'h3, 0, 0, 0, "R2");
        issue(3'd1, 2,   32'h1234_5678, 4'h0, 0, 0, 0, "R2");
        issue(3'd7, 2,   32'hFFFF_0000, 4'hF, 4'hF, 4'h0, 4'hF, "R11 nop");
        issue(3'd1, 3,   32'hFFFF_FFFF, 4'hF, 0, 0, 0, "R2");
        issue(3'd1, 100, 32'hA5A5_5A5A, 4'h6, 0, 0, 0, "R2");
        issue(3'd1, 511, 32'h8000_0000, 4'h9, 0, 0, 0, "R2");
        idle(1);
        quiet(3, "R11 no response for write/nop");
        // R3: back-to-back reads in order
        issue(3'd0, 511, 0, 0, 0, 0, 0, "R3");
        issue(3'd0, 0,   0, 0, 0, 0, 0, "R3");
        issue(3'd0, 2,   0, 0, 0, 0, 0, "R3 after nop");
        issue(3'd0, 100, 0, 0, 0, 0, 0, "R3");
        issue(3'd0, 3,   0, 0, 0, 0, 0, "R3");
        // R7: write then immediate read of the same word
        issue(3'd1, 5, 32'h0BAD_F00D, 4'h5, 0, 0, 0, "R7");
        issue(3'd0, 5, 0, 0, 0, 0, 0, "R7 read after write");
        // R4 / R5: gangs, then reads across the array
        issue(3'd2, 0, 0, 0, 4'b0101, 0, 0, "R4");
        issue(3'd0, 0,   0, 0, 0, 0, 0, "R4");
        issue(3'd0, 511, 0, 0, 0, 0, 0, "R4");
        issue(3'd0, 7,   0, 0, 0, 0, 0, "R4 unwritten word", 1'b0);
        issue(3'd3, 0, 0, 0, 4'b0011, 0, 0, "R5");
        issue(3'd0, 3,   0, 0, 0, 0, 0, "R5");
        issue(3'd0, 100, 0, 0, 0, 0, 0, "R5");
        issue(3'd0, 300, 0, 0, 0, 0, 0, "R5 unwritten word", 1'b0);
        // R6 / R7: read-modify-write and immediate follow-ups
        issue(3'd4, 2, 0, 0, 0, 4'b1100, 4'b0010, "R6");
        issue(3'd0, 2, 0, 0, 0, 0, 0, "R7 read after rmw");
        issue(3'd4, 3, 0, 0, 0, 4'b0110, 4'b0001, "R6");
        issue(3'd4, 3, 0, 0, 0, 4'b1011, 4'b1000, "R7 rmw after rmw");
        issue(3'd5, 3, 32'hFFFF_FFFF, 4'b1001, 4'hF, 0, 0, "R7 cmp after rmw");
        // R8: gang and write right after a read-modify-write
        issue(3'd4, 1, 0, 0, 0, 4'b1111, 4'b1100, "R8");
        issue(3'd3, 0, 0, 0, 4'b1000, 0, 0, "R8");
        issue(3'd0, 1, 0, 0, 0, 0, 0, "R8 gang after rmw");
        issue(3'd4, 100, 0, 0, 0, 4'b0000, 4'b0111, "R8");
        issue(3'd1, 100, 32'hCAFE_0001, 4'h8, 0, 0, 0, "R8");
        issue(3'd0, 100, 0, 0, 0, 0, 0, "R8 write after rmw");
        // R9 / R10: compares
        issue(3'd5, 0, 32'hDEAD_BEEF, mdl_meta[0], 4'hF, 0, 0, "R9 full hit");
        issue(3'd5, 0, 32'hDEAD_BEEE, mdl_meta[0], 4'hF, 0, 0, "R9 data miss");
        issue(3'd5, 0, 32'hDEAD_BEEF, mdl_meta[0] ^ 4'b0100, 4'b1011, 0, 0, "R9 masked bit ignored");
        issue(3'd5, 0, 32'hDEAD_BEEF, mdl_meta[0] ^ 4'b0100, 4'b0100, 0, 0, "R9 meta miss");
        issue(3'd6, 511, 32'h1111_2222, mdl_meta[511], 4'hF, 0, 0, "R10 data ignored");
        issue(3'd6, 511, 32'h1111_2222, mdl_meta[511] ^ 4'b0001, 4'b0001, 0, 0, "R10 meta miss");
        issue(3'd6, 100, 32'h0, 4'h0, 4'h0, 0, 0, "R10 all masked");
        idle(4);
        check(q.size() == 0, "R2 all responses returned", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule